// File: doc/BRIEF.md
# Multi-Scheme Centralized Bus Arbiter

This block is the single decision point that hands a shared bus to one of several masters. Each master raises a request line. The arbiter answers with a one-hot grant vector, the binary index of the granted master and a valid flag. A two-bit scheme input chooses how the arbiter resolves competing requests:

- **Positional chain.** Position 0 is nearest the arbiter. A per-position health input models a broken link in the chain.
- **Rotating poll.** A poll address wraps around the masters, so over time no master is favoured.
- **Independent request lines.** Each master has its own request line, and a fixed priority order decides.

Once granted, a master keeps the bus while it holds its request and keeps its busy indication up. When the master releases the bus, the grant is cleared for one cycle. The next owner is then picked on the following clock edge. This gives an explicit idle cycle at every handover and rules out two owners.

Top module: `bus_arbiter_multi`

## Requirements
- R1: At most one bit of `grant_o` is set at any time. `valid_o` is high exactly when one bit is set, and `owner_o` then holds that bit's index.
- R2: While no master owns the bus, the arbiter decides at each rising edge from the requests sampled there. The grant is visible after that edge and always goes to a master whose request was high at that edge.
- R3: While the owner keeps its request high and `busy_i` does not fall, the grant does not change, whatever other requests arrive.
- R4: The owner releases the bus in either of two ways: by dropping its request, or when `busy_i` goes from 1 to 0. At the edge where the release is seen, the grant clears to zero. A new owner can appear no earlier than the following edge.
- R5: In chain mode (`mode_i` = 0), the requesting master with the lowest index wins. Position i passes the grant on to position i+1 only when `alive_i[i]` is 1 and master i is not requesting. A position with `alive_i` = 0 gets no grant and blocks every higher position.
- R6: In poll mode (`mode_i` = 1), the search starts at the poll pointer and moves up through the indices, wrapping from N-1 to 0. The first requesting master wins. After each poll-mode grant, the pointer becomes the winner's index plus one, modulo N.
- R7: In poll mode, a master that is not requesting is skipped within the same decision, so it never stalls the search. `alive_i` has no effect in this mode.
- R8: In independent mode (`mode_i` = 2 or 3), the requesting master with the highest index wins, and `alive_i` has no effect.
- R9: Reset (`rst_n` low, asynchronous) clears the grant, drives `valid_o` and `owner_o` to 0, and sets the poll pointer to 0.
- R10: When no request is high and no master owns the bus, `grant_o` is zero and `valid_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Scheme: 0 chain, 1 rotating poll, 2 or 3 independent fixed priority |
| req_i | input | N_MASTERS | Per-master bus request |
| alive_i | input | N_MASTERS | Per-chain-position health, used only in chain mode |
| busy_i | input | 1 | Busy indication from the current owner; a falling edge releases the bus |
| grant_o | output | N_MASTERS | One-hot grant |
| owner_o | output | $clog2(N_MASTERS) | Index of the granted master |
| valid_o | output | 1 | A master currently owns the bus |

## Verification
The bench targets the cases where the three schemes give different answers for the same request pattern. With requests 0111, chain mode must pick master 0 and independent mode master 2. A design that mixed up the orderings would grant the wrong master.

In chain mode, a dead position sits between requesters. A design that skipped over it instead of blocking would grant a downstream master it cannot reach.

In poll mode, the bench walks the pointer through a wrap and past silent masters. A pointer that stays fixed, or that stalls on a silent address, would show up as a repeated winner or as a missing grant.

Finally, a higher-priority request arrives while the bus is held. A design that re-arbitrates during ownership, or that skips the idle cycle after `busy_i` falls, would move the grant too early.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

   typedef enum logic [1:0] {
      SCHEME_CHAIN     = 2'd0,
      SCHEME_POLL      = 2'd1,
      SCHEME_INDEP     = 2'd2,
      SCHEME_INDEP_ALT = 2'd3
   } scheme_e;

endpackage

// File: rtl/arb_chain_pick.sv
module arb_chain_pick #(
   parameter int N_MASTERS = 4
) (
   input  logic [N_MASTERS-1:0] req_i,
   input  logic [N_MASTERS-1:0] alive_i,
   output logic [N_MASTERS-1:0] pick_o
);

   logic [N_MASTERS:0] token;

   assign token[0] = 1'b1;

   for (genvar g = 0; g < N_MASTERS; g++) begin : g_link
      // R5: a position forwards the token only if healthy and not taking it
      assign pick_o[g]    = token[g] & alive_i[g] & req_i[g];
      assign token[g + 1] = token[g] & alive_i[g] & ~req_i[g];
   end

endmodule

// File: rtl/arb_rotate_pick.sv
module arb_rotate_pick #(
   parameter int N_MASTERS = 4,
   localparam int IDX_W = $clog2(N_MASTERS)
) (
   input  logic [N_MASTERS-1:0] req_i,
   input  logic [IDX_W-1:0]     ptr_i,
   output logic [N_MASTERS-1:0] pick_o
);

   always_comb begin
      logic found;
      found  = 1'b0;
      pick_o = '0;
      // R7: silent addresses are stepped over in the same decision
      for (int k = 0; k < N_MASTERS; k++) begin
         int unsigned slot;
         slot = (int'(ptr_i) + k) % N_MASTERS;
         if (!found && req_i[slot]) begin
            pick_o[slot] = 1'b1;
            found        = 1'b1;
         end
      end
   end

endmodule

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
   parameter int N_MASTERS = 4
) (
   input  logic [N_MASTERS-1:0] req_i,
   output logic [N_MASTERS-1:0] pick_o
);

   logic [N_MASTERS:0] above;

   assign above[N_MASTERS] = 1'b0;

   for (genvar g = N_MASTERS - 1; g >= 0; g--) begin : g_prio
      // R8: highest index dominates
      assign pick_o[g] = req_i[g] & ~above[g + 1];
      assign above[g]  = above[g + 1] | req_i[g];
   end

endmodule

// File: rtl/bus_arbiter_multi.sv
module bus_arbiter_multi #(
   parameter int N_MASTERS = 4,
   localparam int IDX_W = $clog2(N_MASTERS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           mode_i,
   input  logic [N_MASTERS-1:0] req_i,
   input  logic [N_MASTERS-1:0] alive_i,
   input  logic                 busy_i,
   output logic [N_MASTERS-1:0] grant_o,
   output logic [IDX_W-1:0]     owner_o,
   output logic                 valid_o
);
   import bus_arb_pkg::*;

   if (N_MASTERS < 2) begin : g_bad_count
      $error("bus_arbiter_multi: N_MASTERS must be at least 2");
   end

   function automatic logic [IDX_W-1:0] onehot_index(input logic [N_MASTERS-1:0] v);
      logic [IDX_W-1:0] idx;
      idx = '0;
      for (int i = 0; i < N_MASTERS; i++) begin
         if (v[i]) idx = IDX_W'(i);
      end
      return idx;
   endfunction

   scheme_e             scheme;
   logic [N_MASTERS-1:0] pick_chain, pick_poll, pick_fixed, pick_sel;
   logic [N_MASTERS-1:0] grant_q;
   logic                 valid_q, busy_q;
   logic [IDX_W-1:0]     ptr_q, pick_idx;
   logic                 release_now;

   assign scheme = scheme_e'(mode_i);

   arb_chain_pick #(.N_MASTERS(N_MASTERS)) u_chain (
      .req_i(req_i), .alive_i(alive_i), .pick_o(pick_chain));

   arb_rotate_pick #(.N_MASTERS(N_MASTERS)) u_poll (
      .req_i(req_i), .ptr_i(ptr_q), .pick_o(pick_poll));

   arb_fixed_pick #(.N_MASTERS(N_MASTERS)) u_fixed (
      .req_i(req_i), .pick_o(pick_fixed));

   always_comb begin
      unique case (scheme)
         SCHEME_CHAIN: pick_sel = pick_chain;
         SCHEME_POLL:  pick_sel = pick_poll;
         default:      pick_sel = pick_fixed;
      endcase
   end

   assign pick_idx    = onehot_index(pick_sel);
   // R4: release on dropped request or busy falling edge
   assign release_now = ((grant_q & req_i) == '0) || (busy_q && !busy_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q <= '0;
         valid_q <= 1'b0;
         busy_q  <= 1'b0;
         ptr_q   <= '0;
      end else if (valid_q) begin
         if (release_now) begin
            grant_q <= '0;
            valid_q <= 1'b0;
            busy_q  <= 1'b0;
         end else begin
            busy_q  <= busy_i;
         end
      end else begin
         busy_q <= 1'b0;
         if (pick_sel != '0) begin
            grant_q <= pick_sel;
            valid_q <= 1'b1;
            if (scheme == SCHEME_POLL) begin
               // R6: pointer moves one past the master just served
               ptr_q <= (int'(pick_idx) == N_MASTERS - 1) ? '0 : pick_idx + 1'b1;
            end
         end
      end
   end

   assign grant_o = grant_q;
   assign valid_o = valid_q;
   assign owner_o = onehot_index(grant_q);

   p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o) && (valid_o == (grant_o != '0)));

   p_req_backed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> (($past(req_i) & grant_o) != '0));

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && req_i[owner_o] && busy_i) |=> $stable(grant_o));

   p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !req_i[owner_o]) |=> !valid_o);

   p_chain_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && mode_i == 2'd0 && !alive_i[0]) |=> !valid_o);

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid_o && req_i == '0) |=> !valid_o);

endmodule

// File: tb/bus_arbiter_multi_tb_top.sv
module bus_arbiter_multi_tb_top;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   mode = 2'd0;
   logic [N-1:0] req = '0;
   logic [N-1:0] alive = '1;
   logic         busy = 1'b0;
   logic [N-1:0] grant;
   logic [1:0]   owner;
   logic         valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   bus_arbiter_multi #(.N_MASTERS(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode), .req_i(req), .alive_i(alive),
      .busy_i(busy), .grant_o(grant), .owner_o(owner), .valid_o(valid));

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   task automatic expect_bus(string tag, logic [N-1:0] eg, logic [1:0] eo, logic ev);
      checks++;
      if (grant !== eg || valid !== ev || (ev && owner !== eo)) begin
         fails++;
         $display("FAIL %s: grant=%b owner=%0d valid=%b expected grant=%b owner=%0d valid=%b",
                  tag, grant, owner, valid, eg, eo, ev);
      end
   endtask

   task automatic do_reset();
      req = '0; busy = 1'b0; alive = '1; mode = 2'd0;
      rst_n = 1'b0;
      step();
      step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic free_bus();
      req = '0; busy = 1'b0;
      step();
      step();
   endtask

   task automatic t_reset_idle();
      rst_n = 1'b0;
      step();
      expect_bus("R9 reset state", '0, 2'd0, 1'b0);
      rst_n = 1'b1;
      step();
      step();
      expect_bus("R10 no requests", '0, 2'd0, 1'b0);
   endtask

   task automatic t_chain();
      do_reset();
      mode = 2'd0;
      req = 4'b1010;
      step();
      expect_bus("R5 chain lowest wins", 4'b0010, 2'd1, 1'b1);
      free_bus();
      alive = 4'b1101;
      req = 4'b1100;
      step();
      expect_bus("R5 dead position blocks downstream", '0, 2'd0, 1'b0);
      req = 4'b0001;
      step();
      expect_bus("R5 upstream of dead still served", 4'b0001, 2'd0, 1'b1);
      free_bus();
      alive = '1;
   endtask

   task automatic t_indep();
      do_reset();
      mode = 2'd2;
      alive = '0;
      req = 4'b0111;
      step();
      expect_bus("R8 highest index wins, alive ignored", 4'b0100, 2'd2, 1'b1);
      free_bus();
      mode = 2'd3;
      req = 4'b1001;
      step();
      expect_bus("R8 mode 3 same as independent", 4'b1000, 2'd3, 1'b1);
      free_bus();
      alive = '1;
   endtask

   task automatic t_poll();
      do_reset();
      mode = 2'd1;
      alive = '0;
      req = 4'b1111;
      step();
      expect_bus("R9 poll pointer starts at 0", 4'b0001, 2'd0, 1'b1);
      free_bus();
      req = 4'b1111;
      step();
      expect_bus("R6 pointer advanced to 1", 4'b0010, 2'd1, 1'b1);
      free_bus();
      req = 4'b0001;
      step();
      expect_bus("R7 silent masters 2,3 skipped", 4'b0001, 2'd0, 1'b1);
      free_bus();
      req = 4'b1001;
      step();
      expect_bus("R6 search from 1 reaches 3", 4'b1000, 2'd3, 1'b1);
      free_bus();
      req = 4'b1111;
      step();
      expect_bus("R6 pointer wrapped to 0", 4'b0001, 2'd0, 1'b1);
      free_bus();
      alive = '1;
   endtask

   task automatic t_hold_release();
      do_reset();
      mode = 2'd2;
      req = 4'b0010;
      step();
      expect_bus("R2 grant to requester", 4'b0010, 2'd1, 1'b1);
      busy = 1'b1;
      req = 4'b1010;
      step();
      step();
      step();
      expect_bus("R3 held against higher request", 4'b0010, 2'd1, 1'b1);
      busy = 1'b0;
      step();
      expect_bus("R4 busy fall clears grant", '0, 2'd0, 1'b0);
      step();
      expect_bus("R4 new owner one edge later", 4'b1000, 2'd3, 1'b1);
      busy = 1'b1;
      step();
      req = 4'b0010;
      step();
      expect_bus("R4 dropped request clears grant", '0, 2'd0, 1'b0);
      busy = 1'b0;
      step();
      expect_bus("R1 next owner after drop", 4'b0010, 2'd1, 1'b1);
      free_bus();
      expect_bus("R10 idle after all released", '0, 2'd0, 1'b0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #2;
      t_reset_idle();
      t_chain();
      t_indep();
      t_poll();
      t_hold_release();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule